// File: doc/BRIEF.md
# Off-Core Machine CSR File

This block holds the machine-mode control and status registers of a 64-bit RISC-V core that keeps no CSRs of its own. When a CSR instruction runs, the core places the instruction's 12-bit CSR number on the address input. It also drives a 64-bit value to write and two strobes. The write strobe is raised when the source field (rs1 or zimm) is nonzero. The read strobe is raised when the destination field (rd) is nonzero. In the same cycle, and without any register on the path, the block reports whether the number names an implemented register and returns that register's current value. The core turns a miss into an illegal-instruction trap.

Writes take effect on the clock edge shared with the core. Each writable register has a mask parameter that selects which of its bits software can change. The identification registers, the ISA register and the cycle counter ignore writes. The trap-vector register drives bits 63:2 of a configuration output that the core reads when it enters a trap. That output changes only on the edge that commits a write to the trap vector.

Top module: `csr_bank_ext`

## Requirements
- R1: `csr_exists` is high in the same cycle, combinationally, exactly for these addresses: 0x300 status, 0x301 ISA, 0x305 trap vector, 0x340 scratch, 0x341 exception PC, 0x342 cause, 0xC00 cycle, 0xF11 vendor, 0xF12 architecture, 0xF13 implementation, 0xF14 hart. It is low for every other address.
- R2: `csr_rdata` is zero whenever `csr_rd_en` is low or the address is not implemented.
- R3: With `csr_wr_en` high on a writable register, the next edge loads `(old & ~mask) | (wdata & mask)`. The default masks are: status 0x1888; trap vector and exception PC all ones except bits 1:0; scratch and cause all ones.
- R4: With `csr_wr_en` low, no register changes, whatever `csr_wdata` and the address are.
- R5: Writes to read-only registers (ISA, the four IDs, cycle) or to unimplemented addresses change no state. The read-only registers keep returning their values.
- R6: During and after reset, status, scratch, exception PC and cause read 0. The trap vector reads `TVEC_RESET` masked by its write mask.
- R7: `trap_base` equals trap-vector bits 63:2. It changes only in the cycle after a write to 0x305.
- R8: The cycle register reads 0 in reset and increases by exactly one on every clock edge after reset.
- R9: When both strobes are high on one register in the same cycle, `csr_rdata` shows the old value in that cycle, and a read afterwards shows the new value.
- R10: The ISA, vendor, architecture, implementation and hart registers return their parameter values. The defaults are 0x8000_0000_0000_0100, 0, 0, 1 and 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared with the core |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_addr | input | 12 | CSR number from instruction bits 31:20 |
| csr_wdata | input | 64 | Value offered for write |
| csr_wr_en | input | 1 | Write strobe |
| csr_rd_en | input | 1 | Read strobe |
| csr_exists | output | 1 | Address names an implemented register |
| csr_rdata | output | 64 | Value of the addressed register |
| trap_base | output | 62 | Trap-vector bits 63:2 for the core |

## Verification
The assertions check the following on every cycle:
- the address decoder never selects two registers at once;
- a miss or an idle read strobe returns zero;
- no state moves without a write strobe aimed at a writable register;
- masked-off bits survive every write;
- `trap_base` holds still except after a trap-vector write;
- the counter steps by one on each edge.

Only the directed scenarios can show the rest: the exact set of valid addresses, the identity constants, the reset values, the masked results of particular writes, and the old-then-new ordering of a combined read-write.

// File: rtl/csr_ext_pkg.sv
package csr_ext_pkg;
    localparam int XLEN   = 64;
    localparam int ADDR_W = 12;
    localparam int NUM_RW = 5;
    localparam int NUM_RO = 6;

    // writable register slots
    localparam int RW_STATUS  = 0;
    localparam int RW_TVEC    = 1;
    localparam int RW_SCRATCH = 2;
    localparam int RW_EPC     = 3;
    localparam int RW_CAUSE   = 4;

    localparam logic [ADDR_W-1:0] RW_ADDR [NUM_RW] =
        '{12'h300, 12'h305, 12'h340, 12'h341, 12'h342};

    // read-only slots: isa, vendor, arch, impl, hart, cycle
    localparam logic [ADDR_W-1:0] RO_ADDR [NUM_RO] =
        '{12'h301, 12'hF11, 12'hF12, 12'hF13, 12'hF14, 12'hC00};

    typedef struct packed {
        logic [NUM_RW-1:0][XLEN-1:0] rw;
    } bank_state_t;
endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode
    import csr_ext_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output logic              valid,
    output logic [NUM_RW-1:0] rw_hit,
    output logic [NUM_RO-1:0] ro_hit
);
    for (genvar g = 0; g < NUM_RW; g++) begin : g_rw
        assign rw_hit[g] = (addr == RW_ADDR[g]);
    end
    for (genvar g = 0; g < NUM_RO; g++) begin : g_ro
        assign ro_hit[g] = (addr == RO_ADDR[g]);
    end

    assign valid = (|rw_hit) | (|ro_hit);

    // R1: at most one register selected for any known address
    always_comb begin
        if (!$isunknown(addr)) begin
            assert_decode_onehot_R1: assert ($onehot0({rw_hit, ro_hit}));
        end
    end
endmodule

// File: rtl/csr_tick_counter.sv
module csr_tick_counter #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] count
);
    logic [W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count = count_q;

    assert_tick_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> count_q == $past(count_q) + 1'b1);
endmodule

// File: rtl/csr_bank_ext.sv
module csr_bank_ext
    import csr_ext_pkg::*;
#(
    parameter logic [XLEN-1:0] ISA_VALUE     = 64'h8000_0000_0000_0100,
    parameter logic [XLEN-1:0] VENDOR_ID     = 64'h0,
    parameter logic [XLEN-1:0] ARCH_ID       = 64'h0,
    parameter logic [XLEN-1:0] IMPL_ID       = 64'h1,
    parameter logic [XLEN-1:0] HART_ID       = 64'h0,
    parameter logic [XLEN-1:0] TVEC_RESET    = 64'h0000_0000_0000_1000,
    parameter logic [XLEN-1:0] STATUS_WMASK  = 64'h0000_0000_0000_1888,
    parameter logic [XLEN-1:0] TVEC_WMASK    = 64'hFFFF_FFFF_FFFF_FFFC,
    parameter logic [XLEN-1:0] SCRATCH_WMASK = 64'hFFFF_FFFF_FFFF_FFFF,
    parameter logic [XLEN-1:0] EPC_WMASK     = 64'hFFFF_FFFF_FFFF_FFFC,
    parameter logic [XLEN-1:0] CAUSE_WMASK   = 64'hFFFF_FFFF_FFFF_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [11:0]       csr_addr,
    input  logic [63:0]       csr_wdata,
    input  logic              csr_wr_en,
    input  logic              csr_rd_en,
    output logic              csr_exists,
    output logic [63:0]       csr_rdata,
    output logic [61:0]       trap_base
);
    localparam logic [NUM_RW-1:0][XLEN-1:0] WMASK =
        {CAUSE_WMASK, EPC_WMASK, SCRATCH_WMASK, TVEC_WMASK, STATUS_WMASK};
    localparam logic [NUM_RW-1:0][XLEN-1:0] RST_VAL =
        {{XLEN{1'b0}}, {XLEN{1'b0}}, {XLEN{1'b0}},
         TVEC_RESET & TVEC_WMASK, {XLEN{1'b0}}};

    logic [NUM_RW-1:0]           rw_hit;
    logic [NUM_RO-1:0]           ro_hit;
    logic [XLEN-1:0]             cycle_cnt;
    logic [NUM_RO-1:0][XLEN-1:0] ro_val;
    bank_state_t                 state_d, state_q;

    csr_addr_decode u_dec (
        .addr   (csr_addr),
        .valid  (csr_exists),
        .rw_hit (rw_hit),
        .ro_hit (ro_hit)
    );

    csr_tick_counter #(.W(XLEN)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .count (cycle_cnt)
    );

    assign ro_val = {cycle_cnt, HART_ID, IMPL_ID, ARCH_ID, VENDOR_ID, ISA_VALUE};

    // next state: masked merge into the addressed writable register
    always_comb begin
        state_d = state_q;
        for (int i = 0; i < NUM_RW; i++) begin
            if (csr_wr_en && rw_hit[i]) begin
                state_d.rw[i] = (state_q.rw[i] & ~WMASK[i]) | (csr_wdata & WMASK[i]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '{rw: RST_VAL};
        else        state_q <= state_d;
    end

    // read path: gated by the read strobe, zero on a miss
    always_comb begin
        csr_rdata = '0;
        if (csr_rd_en) begin
            for (int i = 0; i < NUM_RW; i++) begin
                if (rw_hit[i]) csr_rdata = csr_rdata | state_q.rw[i];
            end
            for (int i = 0; i < NUM_RO; i++) begin
                if (ro_hit[i]) csr_rdata = csr_rdata | ro_val[i];
            end
        end
    end

    assign trap_base = state_q.rw[RW_TVEC][XLEN-1:2];

    // ---------------- assertions ----------------
    assert_miss_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!csr_exists || !csr_rd_en) |-> csr_rdata == '0);

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_wr_en |=> $stable(state_q));

    assert_ro_write_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr_en && !(|rw_hit)) |=> $stable(state_q));

    assert_tvec_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(csr_wr_en && csr_addr == RW_ADDR[RW_TVEC]) |=> $stable(trap_base));

    for (genvar g = 0; g < NUM_RW; g++) begin : g_mask_chk
        assert_mask_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (csr_wr_en && rw_hit[g]) |=>
            ((state_q.rw[g] ^ $past(state_q.rw[g])) & ~WMASK[g]) == '0);
    end
endmodule

// File: tb/csr_bank_ext_tb_top.sv
module csr_bank_ext_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] csr_addr;
    logic [63:0] csr_wdata;
    logic        csr_wr_en;
    logic        csr_rd_en;
    logic        csr_exists;
    logic [63:0] csr_rdata;
    logic [61:0] trap_base;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    csr_bank_ext dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .csr_addr   (csr_addr),
        .csr_wdata  (csr_wdata),
        .csr_wr_en  (csr_wr_en),
        .csr_rd_en  (csr_rd_en),
        .csr_exists (csr_exists),
        .csr_rdata  (csr_rdata),
        .trap_base  (trap_base)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [63:0] v, output logic ex);
        @(negedge clk);
        csr_addr = a; csr_wr_en = 1'b0; csr_rd_en = 1'b1;
        #2;
        v = csr_rdata; ex = csr_exists;
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        @(negedge clk);
        csr_addr = a; csr_wdata = d; csr_wr_en = 1'b1; csr_rd_en = 1'b0;
        @(posedge clk);
        #1 csr_wr_en = 1'b0;
    endtask

    task automatic t_reset;
        logic [63:0] v; logic ex;
        rst_n = 1'b0; csr_addr = '0; csr_wdata = '0; csr_wr_en = 0; csr_rd_en = 0;
        repeat (3) @(posedge clk);
        rd(12'hC00, v, ex); chk("R8 cycle in reset", v, 64'h0);
        @(negedge clk); rst_n = 1'b1;
        rd(12'h300, v, ex); chk("R6 status reset", v, 64'h0);
        rd(12'h340, v, ex); chk("R6 scratch reset", v, 64'h0);
        rd(12'h341, v, ex); chk("R6 epc reset", v, 64'h0);
        rd(12'h342, v, ex); chk("R6 cause reset", v, 64'h0);
        rd(12'h305, v, ex); chk("R6 tvec reset", v, 64'h1000);
        chk("R7 trap_base reset", {2'b00, trap_base}, 64'h400);
    endtask

    task automatic t_valid;
        logic [63:0] v; logic ex;
        logic [11:0] good [11] = '{12'h300, 12'h301, 12'h305, 12'h340, 12'h341,
                                   12'h342, 12'hC00, 12'hF11, 12'hF12, 12'hF13, 12'hF14};
        logic [11:0] bad [6] = '{12'h000, 12'h302, 12'h306, 12'h343, 12'hB00, 12'hFFF};
        foreach (good[i]) begin rd(good[i], v, ex); chk("R1 mapped", {63'b0, ex}, 64'h1); end
        foreach (bad[i]) begin
            rd(bad[i], v, ex);
            chk("R1 unmapped", {63'b0, ex}, 64'h0);
            chk("R2 unmapped reads zero", v, 64'h0);
        end
    endtask

    task automatic t_ids;
        logic [63:0] v; logic ex;
        rd(12'h301, v, ex); chk("R10 isa", v, 64'h8000_0000_0000_0100);
        rd(12'hF11, v, ex); chk("R10 vendor", v, 64'h0);
        rd(12'hF12, v, ex); chk("R10 arch", v, 64'h0);
        rd(12'hF13, v, ex); chk("R10 impl", v, 64'h1);
        rd(12'hF14, v, ex); chk("R10 hart", v, 64'h0);
    endtask

    task automatic t_rd_gate;
        @(negedge clk);
        csr_addr = 12'h305; csr_rd_en = 1'b0; csr_wr_en = 1'b0;
        #2 chk("R2 strobe low reads zero", csr_rdata, 64'h0);
    endtask

    task automatic t_write;
        logic [63:0] v; logic ex;
        wr(12'h340, 64'hDEAD_BEEF_0123_4567);
        rd(12'h340, v, ex); chk("R3 scratch write", v, 64'hDEAD_BEEF_0123_4567);
        wr(12'h300, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(12'h300, v, ex); chk("R3 status masked", v, 64'h1888);
        wr(12'h341, 64'h0000_0000_8000_0007);
        rd(12'h341, v, ex); chk("R3 epc masked", v, 64'h0000_0000_8000_0004);
        wr(12'h342, 64'h8000_0000_0000_000B);
        rd(12'h342, v, ex); chk("R3 cause write", v, 64'h8000_0000_0000_000B);
        @(negedge clk);
        csr_addr = 12'h305; csr_wdata = 64'h1234_5678_9ABC_DEF3; csr_wr_en = 1'b1; csr_rd_en = 1'b0;
        #2 chk("R7 trap_base before edge", {2'b00, trap_base}, 64'h400);
        @(posedge clk); #1 csr_wr_en = 1'b0;
        chk("R7 trap_base after write", {2'b00, trap_base}, 64'h1234_5678_9ABC_DEF3 >> 2);
        rd(12'h305, v, ex); chk("R3 tvec masked", v, 64'h1234_5678_9ABC_DEF0);
    endtask

    task automatic t_no_strobe;
        logic [63:0] v; logic ex;
        @(negedge clk);
        csr_addr = 12'h340; csr_wdata = 64'h5555_AAAA_5555_AAAA; csr_wr_en = 1'b0; csr_rd_en = 1'b0;
        repeat (2) @(posedge clk);
        rd(12'h340, v, ex); chk("R4 no strobe scratch kept", v, 64'hDEAD_BEEF_0123_4567);
    endtask

    task automatic t_ro_write;
        logic [63:0] v, a, b; logic ex;
        wr(12'h301, 64'h0);
        rd(12'h301, v, ex); chk("R5 isa write ignored", v, 64'h8000_0000_0000_0100);
        wr(12'hF14, 64'h7);
        rd(12'hF14, v, ex); chk("R5 hart write ignored", v, 64'h0);
        rd(12'hC00, a, ex);
        wr(12'hC00, 64'h0);
        rd(12'hC00, b, ex); chk("R5 cycle write ignored", b - a, 64'd2);
        wr(12'h343, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(12'h340, v, ex); chk("R5 unmapped write scratch kept", v, 64'hDEAD_BEEF_0123_4567);
        rd(12'h300, v, ex); chk("R5 unmapped write status kept", v, 64'h1888);
    endtask

    task automatic t_cycle;
        logic [63:0] a, b; logic ex;
        rd(12'hC00, a, ex);
        repeat (6) @(negedge clk);
        #2 b = csr_rdata;
        chk("R8 cycle step", b - a, 64'd6);
    endtask

    task automatic t_rw_same;
        logic [63:0] v; logic ex;
        @(negedge clk);
        csr_addr = 12'h340; csr_wdata = 64'h0F0F_0F0F_0F0F_0F0F; csr_wr_en = 1'b1; csr_rd_en = 1'b1;
        #2 chk("R9 old value in same cycle", csr_rdata, 64'hDEAD_BEEF_0123_4567);
        @(posedge clk); #1 csr_wr_en = 1'b0;
        rd(12'h340, v, ex); chk("R9 new value after", v, 64'h0F0F_0F0F_0F0F_0F0F);
    endtask

    initial begin
        #(20 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset;
        t_valid;
        t_ids;
        t_rd_gate;
        t_write;
        t_no_strobe;
        t_ro_write;
        t_cycle;
        t_rw_same;
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule